// File: doc/BRIEF.md
# I2C EEPROM Transaction Sequencer

This block turns one host request into the ordered series of byte-level commands that a separate I2C bit engine executes. There are three request kinds: a presence probe, a memory read and a memory write. A request carries a 7-bit device address, an internal memory address of zero, one or two bytes, and a byte count. Each command goes to the engine over a valid/ready pair. The engine reports that the command has finished with a one-cycle pulse. For written bytes that pulse carries the sampled acknowledge, and for read bytes it carries the received byte.

Write data enters and read data leaves through valid/ready streams. When a request finishes, the block raises a one-cycle done pulse and holds an error flag and a count of refused data bytes until the next request starts. Two behaviours differ from a textbook master. The read path re-addresses the device with a full STOP and a fresh START rather than a repeated start. The internal-address bits above the bytes actually sent can be merged into the device address under a parameter mask, so a larger memory answers as several 256-byte devices.

Top module: `i2c_txn_seq`

## Requirements
- R1: Engine command codes are 0 = START, 1 = STOP, 2 = WRITE byte, 3 = READ byte. Host request codes are 0 = probe, 1 = read, 2 = write. A probe issues START, then WRITE of {device, 0}, then STOP. It sets the error flag exactly when that byte was not acknowledged (engine nack = 1).
- R2: A read with an address length of 1 or 2 issues START and WRITE {device, 0}. It then writes the address bytes, most significant first, then STOP, START and WRITE {device, 1}.
- R3: A read with an address length of 0 skips the addressing phase. It issues START and then WRITE {device, 1} directly.
- R4: If the device byte of a write phase (read or write request) is not acknowledged, the block issues STOP, sets the error flag and finishes.
- R5: If an internal-address byte is not acknowledged, the block sets the error flag and finishes without issuing STOP.
- R6: A read issues one READ command per byte. The acknowledge-level output is 0 on every READ except the last, where it is 1. STOP follows the last byte. The bytes appear on the read stream in the order received and are held until taken.
- R7: In a write, every data byte is taken from the write stream and sent. Each byte that is not acknowledged adds one to the failure count and the transfer goes on. STOP is always sent, and the error flag stays clear.
- R8: The device address sent is the request's device address ORed with (internal address shifted right by 8 × address length) masked by the parameter OVF_MASK (default 7'h07).
- R9: The acknowledge sampled on the read-phase device byte is ignored, and reading proceeds.
- R10: A read with a count of 0 issues STOP right after the last address byte, or right after WRITE {device, 1} when the address length is 0, and then finishes.
- R11: After reset the block is idle, with no command, no stream handshake and done low. Done is a single-cycle pulse at the end of every request.
- R12: A command offered to the engine keeps its code, byte and acknowledge level unchanged until the engine accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| op_i | input | 2 | Request kind: 0 probe, 1 read, 2 write |
| dev_i | input | 7 | Device address |
| addr_i | input | ADDR_W | Internal memory address |
| alen_i | input | 2 | Address bytes to send, 0 to 2 |
| count_i | input | CNT_W | Data bytes to move |
| wr_data_i | input | 8 | Write stream data |
| wr_valid_i | input | 1 | Write stream valid |
| wr_ready_o | output | 1 | Write stream ready |
| rd_data_o | output | 8 | Read stream data |
| rd_valid_o | output | 1 | Read stream valid |
| rd_ready_i | input | 1 | Read stream ready |
| cmd_valid_o | output | 1 | Command offered to the engine |
| cmd_ready_i | input | 1 | Engine accepts the command |
| cmd_op_o | output | 2 | Command code |
| cmd_byte_o | output | 8 | Byte for a WRITE command |
| cmd_nack_o | output | 1 | Acknowledge level to drive after a READ |
| eng_done_i | input | 1 | Engine finished the accepted command |
| eng_nack_i | input | 1 | Sampled acknowledge bit of a WRITE, 1 = refused |
| eng_rdata_i | input | 8 | Byte received by a READ |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Request ended on a refused device or address byte |
| fail_cnt_o | output | CNT_W | Refused data bytes in the last write |

## Verification
The bench covers each request kind with each address length, and with acknowledge patterns where every byte is accepted and where a refusal lands on a specific byte. The full command list is compared, so it shows where a request stopped and whether a STOP closed it. A refusal on the device byte, on an address byte, on the read-phase device byte and on data bytes each gives a different expected tail, so those cases separate the fatal, silent-abort, ignored and counted outcomes. Random ready and valid gaps on the engine and both streams check that ordering and data do not depend on handshake timing. Requests whose upper address bits are set check the folding into the device byte.

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq #(
  parameter int ADDR_W = 16,
  parameter int CNT_W = 8,
  parameter logic [6:0] OVF_MASK = 7'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [6:0]        dev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        alen_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [7:0]        cmd_byte_o,
  output logic              cmd_nack_o,
  input  logic              eng_done_i,
  input  logic              eng_nack_i,
  input  logic [7:0]        eng_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  fail_cnt_o
);
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WR = 2'd2, C_RD = 2'd3;
  localparam logic [1:0] Q_READ = 2'd1, Q_WRITE = 2'd2;

  typedef enum logic [3:0] {
    P_IDLE, P_START, P_DEVW, P_ADDR, P_MSTOP, P_RSTART, P_DEVR,
    P_RD, P_RDOUT, P_WGET, P_WR, P_STOP
  } phase_t;

  phase_t             phase;
  logic               wait_q;
  logic [1:0]         op_q;
  logic [6:0]         dev_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [1:0]         alen_q, idx_q;
  logic [CNT_W-1:0]   rem_q;
  logic [7:0]         byte_q;

  logic [ADDR_W-1:0]  hi_bits;
  logic [ADDR_W-1:0]  addr_sh;
  logic               is_cmd;

  assign hi_bits = addr_i >> {alen_i, 3'b000};
  assign addr_sh = addr_q >> {idx_q, 3'b000};

  always_comb begin
    is_cmd     = 1'b1;
    cmd_op_o   = C_WR;
    cmd_byte_o = 8'h00;
    unique case (phase)
      P_START, P_RSTART: cmd_op_o = C_START;
      P_MSTOP, P_STOP:   cmd_op_o = C_STOP;
      P_DEVW:            cmd_byte_o = {dev_q, 1'b0};
      P_DEVR:            cmd_byte_o = {dev_q, 1'b1};
      P_ADDR:            cmd_byte_o = addr_sh[7:0];
      P_WR:              cmd_byte_o = byte_q;
      P_RD:              cmd_op_o = C_RD;
      default:           is_cmd = 1'b0;
    endcase
  end

  assign cmd_valid_o = is_cmd && !wait_q;
  assign cmd_nack_o  = (phase == P_RD) && (rem_q == CNT_W'(1));
  assign wr_ready_o  = (phase == P_WGET);
  assign rd_valid_o  = (phase == P_RDOUT);
  assign rd_data_o   = byte_q;
  assign busy_o      = (phase != P_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE; wait_q <= 1'b0; op_q <= '0; dev_q <= '0; addr_q <= '0;
      alen_q <= '0; idx_q <= '0; rem_q <= '0; byte_q <= '0;
      done_o <= 1'b0; err_o <= 1'b0; fail_cnt_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (phase)
        P_IDLE: if (start_i) begin
          op_q <= op_i; alen_q <= alen_i; addr_q <= addr_i; rem_q <= count_i;
          dev_q <= dev_i | (hi_bits[6:0] & OVF_MASK);
          err_o <= 1'b0; fail_cnt_o <= '0; phase <= P_START;
        end
        P_RDOUT: if (rd_ready_i) begin
          rem_q <= rem_q - 1'b1;
          phase <= (rem_q == CNT_W'(1)) ? P_STOP : P_RD;
        end
        P_WGET: if (wr_valid_i) begin
          byte_q <= wr_data_i;
          phase  <= P_WR;
        end
        default: if (!wait_q) begin
          if (cmd_ready_i) wait_q <= 1'b1;
        end else if (eng_done_i) begin
          wait_q <= 1'b0;
          case (phase)
            P_START: phase <= (op_q == Q_READ && alen_q == 2'd0) ? P_DEVR : P_DEVW;
            P_DEVW:
              if (eng_nack_i) begin err_o <= 1'b1; phase <= P_STOP; end
              else if (op_q != Q_READ && op_q != Q_WRITE) phase <= P_STOP;
              else if (alen_q != 2'd0) begin idx_q <= alen_q - 1'b1; phase <= P_ADDR; end
              else phase <= (rem_q == '0) ? P_STOP : P_WGET;
            P_ADDR:
              if (eng_nack_i) begin err_o <= 1'b1; done_o <= 1'b1; phase <= P_IDLE; end
              else if (idx_q != 2'd0) idx_q <= idx_q - 1'b1;
              else if (rem_q == '0) phase <= P_STOP;
              else phase <= (op_q == Q_READ) ? P_MSTOP : P_WGET;
            P_MSTOP:  phase <= P_RSTART;
            P_RSTART: phase <= P_DEVR;
            P_DEVR:   phase <= (rem_q == '0) ? P_STOP : P_RD;
            P_RD: begin byte_q <= eng_rdata_i; phase <= P_RDOUT; end
            P_WR: begin
              if (eng_nack_i) fail_cnt_o <= fail_cnt_o + 1'b1;
              rem_q <= rem_q - 1'b1;
              phase <= (rem_q == CNT_W'(1)) ? P_STOP : P_WGET;
            end
            default: begin done_o <= 1'b1; phase <= P_IDLE; end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic             busy_o,
  input logic             cmd_valid_o,
  input logic             cmd_ready_i,
  input logic [1:0]       cmd_op_o,
  input logic [7:0]       cmd_byte_o,
  input logic             cmd_nack_o,
  input logic             rd_valid_o,
  input logic             rd_ready_i,
  input logic [7:0]       rd_data_o,
  input logic             wr_ready_o,
  input logic [CNT_W-1:0] fail_cnt_o
);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!cmd_valid_o && !rd_valid_o && !wr_ready_o));

  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_op_o)
      && $stable(cmd_byte_o) && $stable(cmd_nack_o)));

  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  a_r7_fail_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (fail_cnt_o >= $past(fail_cnt_o)));
endmodule

bind i2c_txn_seq i2c_txn_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o), .busy_o(busy_o),
  .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_op_o(cmd_op_o),
  .cmd_byte_o(cmd_byte_o), .cmd_nack_o(cmd_nack_o), .rd_valid_o(rd_valid_o),
  .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o), .wr_ready_o(wr_ready_o),
  .fail_cnt_o(fail_cnt_o)
);

// File: tb/i2c_txn_seq_bench.sv
module i2c_txn_seq_bench;
  localparam logic [6:0] OVF = 7'h07;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] op_i = '0, alen_i = '0;
  logic [6:0] dev_i = '0;
  logic [15:0] addr_i = '0;
  logic [7:0] count_i = '0;
  logic [7:0] wr_data_i;
  logic wr_valid_i, wr_ready_o, rd_valid_o, rd_ready_i;
  logic [7:0] rd_data_o;
  logic cmd_valid_o, cmd_ready_i, cmd_nack_o, eng_done_i, eng_nack_i;
  logic [1:0] cmd_op_o;
  logic [7:0] cmd_byte_o, eng_rdata_i;
  logic busy_o, done_o, err_o;
  logic [7:0] fail_cnt_o;

  i2c_txn_seq u_i2c_txn_seq (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int log_w[128]; int n_log = 0;
  int exp_w[128]; int n_exp = 0;
  logic [7:0] got[64]; int n_got = 0;
  logic [31:0] nack_mask = '0;
  int w_idx = 0, r_idx = 0, wcnt = 0;
  logic exp_err; int exp_fail;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // engine model
  initial begin : engine
    bit pend = 0; int dly = 0; logic r_nack = 0; logic [7:0] r_data = 0;
    cmd_ready_i = 0; eng_done_i = 0; eng_nack_i = 0; eng_rdata_i = 0;
    forever begin
      @(negedge clk);
      eng_done_i = 0;
      if (pend) begin
        cmd_ready_i = 0;
        if (dly == 0) begin
          eng_done_i = 1; eng_nack_i = r_nack; eng_rdata_i = r_data; pend = 0;
        end else dly--;
      end else begin
        cmd_ready_i = ($urandom % 4) != 0;
        if (rst_n && cmd_valid_o && cmd_ready_i) begin
          if (n_log < 128)
            log_w[n_log] = cmd_op_o * 512 + (cmd_op_o == 2 ? cmd_byte_o * 2 : 0)
                           + (cmd_op_o == 3 ? int'(cmd_nack_o) : 0);
          n_log++;
          pend = 1; dly = $urandom % 3; r_nack = 0; r_data = 0;
          if (cmd_op_o == 2) begin
            r_nack = (w_idx < 32) ? nack_mask[w_idx] : 1'b0; w_idx++;
          end
          if (cmd_op_o == 3) begin r_data = 8'(8'hA0 + r_idx); r_idx++; end
        end
      end
    end
  end

  // stream host model
  initial begin
    wr_valid_i = 0; rd_ready_i = 0; wr_data_i = 0;
    forever begin
      @(negedge clk);
      wr_valid_i = ($urandom % 3) != 0;
      wr_data_i = 8'(8'h30 + wcnt);
      if (wr_valid_i && wr_ready_o) wcnt++;
      rd_ready_i = ($urandom % 3) != 0;
      if (rd_valid_o && rd_ready_i) begin
        if (n_got < 64) got[n_got] = rd_data_o;
        n_got++;
      end
    end
  end

  function automatic void push(input int op, input int b, input int nk);
    exp_w[n_exp] = op * 512 + b * 2 + nk; n_exp++;
  endfunction

  function automatic void build_exp(input int op, input logic [6:0] dev,
      input logic [15:0] addr, input int alen, input int cnt, input logic [31:0] m);
    logic [15:0] hi; logic [6:0] d; int wi = 0;
    hi = addr >> (alen * 8);
    d = dev | (hi[6:0] & OVF);
    n_exp = 0; exp_err = 0; exp_fail = 0;
    push(0, 0, 0);
    if (op == 0) begin
      push(2, {d, 1'b0}, 0); exp_err = m[0]; push(1, 0, 0); return;
    end
    if (op == 2 || alen > 0) begin
      push(2, {d, 1'b0}, 0);
      if (m[wi]) begin exp_err = 1; push(1, 0, 0); return; end
      wi++;
      for (int i = alen - 1; i >= 0; i--) begin
        push(2, int'(addr >> (i * 8)) & 255, 0);
        if (m[wi]) begin exp_err = 1; return; end
        wi++;
      end
      if (op == 2) begin
        for (int k = 0; k < cnt; k++) begin
          push(2, 8'h30 + k, 0);
          if (m[wi]) exp_fail++;
          wi++;
        end
        push(1, 0, 0); return;
      end
      if (cnt == 0) begin push(1, 0, 0); return; end
      push(1, 0, 0); push(0, 0, 0);
    end
    push(2, {d, 1'b1}, 0);
    for (int k = 0; k < cnt; k++) push(3, 0, (k == cnt - 1) ? 1 : 0);
    push(1, 0, 0);
  endfunction

  task automatic run_txn(input int op, input logic [6:0] dev, input logic [15:0] addr,
      input int alen, input int cnt, input logic [31:0] m, input string tag);
    bit seen = 0; int first_bad = -1;
    @(negedge clk);
    n_log = 0; w_idx = 0; r_idx = 0; wcnt = 0; n_got = 0; nack_mask = m;
    build_exp(op, dev, addr, alen, cnt, m);
    op_i = 2'(op); dev_i = dev; addr_i = addr; alen_i = 2'(alen); count_i = 8'(cnt);
    start_i = 1;
    @(negedge clk); start_i = 0;
    for (int k = 0; k < 5000; k++) begin
      if (done_o) begin seen = 1; break; end
      @(negedge clk);
    end
    check(seen, {tag, " R11 done"}, seen, 1);
    if (!seen) return;
    @(negedge clk);
    check(!done_o, {tag, " R11 pulse"}, done_o, 0);
    check(n_log == n_exp, {tag, " R12 cmd count"}, n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++)
      if (first_bad < 0 && log_w[i] != exp_w[i]) first_bad = i;
    check(first_bad < 0, {tag, " R12 cmd seq"},
          first_bad < 0 ? 0 : log_w[first_bad], first_bad < 0 ? 0 : exp_w[first_bad]);
    check(err_o == exp_err, {tag, " err"}, err_o, exp_err);
    if (op == 2 && !exp_err)
      check(fail_cnt_o == exp_fail, {tag, " R7 fail count"}, fail_cnt_o, exp_fail);
    if (op == 1 && !exp_err) begin
      check(n_got == cnt, {tag, " R6 read count"}, n_got, cnt);
      for (int i = 0; i < cnt && i < n_got; i++)
        check(got[i] == 8'(8'hA0 + i), {tag, " R6 read data"}, got[i], 8'hA0 + i);
    end
    if (op == 2 && !exp_err)
      check(wcnt == cnt, {tag, " R7 bytes taken"}, wcnt, cnt);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!busy_o && !cmd_valid_o && !done_o && !wr_ready_o && !rd_valid_o,
          "R11 reset state", {busy_o, cmd_valid_o, done_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_txn(0, 7'h50, 16'h0000, 0, 0, 32'h0, "R1 probe present");
    run_txn(0, 7'h51, 16'h0000, 0, 0, 32'h1, "R1 probe absent");
    run_txn(1, 7'h50, 16'h1234, 2, 3, 32'h0, "R2 R6 read alen2");
    run_txn(1, 7'h50, 16'h0010, 0, 2, 32'h0, "R3 read alen0");
    run_txn(1, 7'h50, 16'h0010, 1, 2, 32'h1, "R4 read dev nack");
    run_txn(2, 7'h50, 16'h0010, 1, 2, 32'h1, "R4 write dev nack");
    run_txn(2, 7'h50, 16'h1234, 2, 2, 32'h4, "R5 write addr nack");
    run_txn(1, 7'h50, 16'h1234, 2, 2, 32'h2, "R5 read addr nack");
    run_txn(2, 7'h50, 16'h0044, 1, 4, 32'h14, "R7 write data nacks");
    run_txn(1, 7'h50, 16'h0234, 1, 1, 32'h0, "R8 overflow fold");
    run_txn(1, 7'h50, 16'h0034, 1, 2, 32'h4, "R9 read dev ack ignored");
    run_txn(1, 7'h50, 16'h0034, 1, 0, 32'h0, "R10 read zero count");
    run_txn(1, 7'h50, 16'h0034, 0, 0, 32'h0, "R10 read zero count alen0");
    for (int t = 0; t < 40; t++) begin
      int op = $urandom % 3;
      logic [31:0] m = (($urandom % 4) == 0) ? $urandom : 32'h0;
      run_txn(op, 7'($urandom), 16'($urandom), $urandom % 3, $urandom % 5, m,
              "random R1 R2 R3 R7 R8");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule